// File: doc/BRIEF.md
# Poisoned Parity Forwarding Controller

This block sits in the forwarding path between an upstream link and a downstream parallel bus that carries even parity. Each upstream beat arrives with a 32-bit data word, a 4-bit byte-enable field, a beat kind and a flag that says whether the beat arrived with bad parity. The block registers each beat once and sends it downstream with a freshly computed parity bit.

When forwarding is armed by the enable input and a beat arrives marked bad, the block enters a poisoned mode. That beat and every beat after it leave with their parity bit inverted. A downstream agent that checks parity therefore rejects the data instead of taking it in unknowingly. The mode is shown on a sticky status output. A write-one clear strobe drops both the status and the mode.

Both write-data beats and read-completion beats can trigger the mode. The parity generator can be built flat or as a byte-lane tree. The two forms give the same result.

Top module: `ppf_ctrl`

## Requirements
- R1: After reset, dn_valid and poison_sts are low.
- R2: A beat presented with up_valid high appears one clock later with dn_valid high and dn_data and dn_be unchanged. dn_valid is low one clock after a cycle with up_valid low.
- R3: Outside poisoned mode, dn_par equals the XOR of all 32 data bits and all 4 byte-enable bits, so the 37 downstream bits hold an even number of ones.
- R4: A valid beat with up_perr high while poison_en is high is itself sent with dn_par inverted from the R3 value.
- R5: poison_sts goes high one clock after such a beat. It then stays high until a clear strobe.
- R6: While poisoned mode is active, every valid beat is sent with inverted parity, whether or not it carries up_perr.
- R7: An error beat enters the mode for either kind: up_kind 0 (write data) or up_kind 1 (read-completion data).
- R8: With poison_en low, up_perr has no effect on dn_par, and poison_sts stays low.
- R9: A sts_clr pulse leaves poisoned mode, and poison_sts is low one clock later. A beat presented in the same cycle as the pulse, with no enabled error of its own, is sent with normal parity.
- R10: If an enabled error beat arrives in the same cycle as sts_clr, the set wins: the beat is inverted and poison_sts is high one clock later.
- R11: up_perr in a cycle with up_valid low does not enter the mode.
- R12: Lowering poison_en while in poisoned mode does not leave it. Beats stay inverted until sts_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_valid | input | 1 | Upstream beat present |
| up_data | input | 32 | Upstream data word |
| up_be | input | 4 | Upstream byte enables |
| up_perr | input | 1 | Upstream beat arrived with bad parity |
| up_kind | input | 1 | 0 = write data, 1 = read-completion data |
| poison_en | input | 1 | Arms entry into poisoned mode |
| sts_clr | input | 1 | Write-one clear of status and mode |
| dn_valid | output | 1 | Downstream beat present |
| dn_data | output | 32 | Downstream data word |
| dn_be | output | 4 | Downstream byte enables |
| dn_par | output | 1 | Downstream parity bit (even, or inverted when poisoned) |
| poison_sts | output | 1 | Sticky poisoned-mode status |

## Verification
The bench checks the error beat itself. A design that started inverting only one beat late would let the corrupted word through with good parity. It lowers the enable while the mode is active, where a design that gated the mode with the enable would quietly fall back to good parity. It presents a clear together with a plain beat, and a clear together with a new error. Getting the priority wrong there either inverts a good beat after the clear or loses a fresh error. It also raises the error flag with no valid beat and while disarmed, where a careless trigger would latch the mode when it should not.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
   typedef enum logic {
      BEAT_WR  = 1'b0,
      BEAT_RDC = 1'b1
   } beat_kind_e;

   localparam int unsigned PAR_FLAT = 0;
   localparam int unsigned PAR_TREE = 1;
endpackage

// File: rtl/ppf_parity_gen.sv
module ppf_parity_gen #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BE_W   = 4,
   parameter int unsigned STYLE  = ppf_pkg::PAR_TREE
) (
   input  logic [DATA_W-1:0] data,
   input  logic [BE_W-1:0]   be,
   output logic              par
);
   localparam int unsigned LANE_W = DATA_W / BE_W;

   initial begin
      if (DATA_W % BE_W != 0) $error("ppf_parity_gen: DATA_W must split evenly into BE_W lanes");
      if (STYLE > 1) $error("ppf_parity_gen: unknown STYLE");
   end

   generate
      if (STYLE == ppf_pkg::PAR_FLAT) begin : g_flat
         assign par = ^{data, be};
      end else begin : g_tree
         logic [BE_W-1:0] lane_par;
         for (genvar i = 0; i < BE_W; i++) begin : g_lane
            assign lane_par[i] = (^data[i*LANE_W +: LANE_W]) ^ be[i];
         end
         assign par = ^lane_par;
      end
   endgenerate
endmodule

// File: rtl/ppf_trigger.sv
module ppf_trigger #(
   parameter bit ARM_ON_WR  = 1'b1,
   parameter bit ARM_ON_RDC = 1'b1
) (
   input  logic valid,
   input  logic perr,
   input  logic kind,
   input  logic en,
   output logic hit
);
   import ppf_pkg::*;
   beat_kind_e kind_e;
   logic       kind_armed;

   always_comb begin
      kind_e     = beat_kind_e'(kind);
      kind_armed = (kind_e == BEAT_WR) ? ARM_ON_WR : ARM_ON_RDC;
      hit        = valid & perr & en & kind_armed;
   end
endmodule

// File: rtl/ppf_poison_ctl.sv
module ppf_poison_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr,
   output logic mode_q,
   output logic inv_now
);
   logic mode_d;

   always_comb begin
      inv_now = hit | (mode_q & ~clr);
      mode_d  = inv_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= mode_d;
   end

   p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> mode_q);
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !clr) |=> mode_q);
   p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> !mode_q);
   p_noset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && !hit) |=> !mode_q);
endmodule

// File: rtl/ppf_out_stage.sv
module ppf_out_stage #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [BE_W-1:0]   in_be,
   input  logic              in_par,
   input  logic              in_inv,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [BE_W-1:0]   out_be,
   output logic              out_par
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_be    <= '0;
         out_par   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= in_data;
            out_be   <= in_be;
            out_par  <= in_par ^ in_inv;
         end
      end
   end

   p_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_data == $past(in_data) && out_be == $past(in_be)));
endmodule

// File: rtl/ppf_ctrl.sv
module ppf_ctrl #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned BE_W       = 4,
   parameter int unsigned PAR_STYLE  = ppf_pkg::PAR_TREE,
   parameter bit          ARM_ON_WR  = 1'b1,
   parameter bit          ARM_ON_RDC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   input  logic [DATA_W-1:0] up_data,
   input  logic [BE_W-1:0]   up_be,
   input  logic              up_perr,
   input  logic              up_kind,
   input  logic              poison_en,
   input  logic              sts_clr,
   output logic              dn_valid,
   output logic [DATA_W-1:0] dn_data,
   output logic [BE_W-1:0]   dn_be,
   output logic              dn_par,
   output logic              poison_sts
);
   initial begin
      if (DATA_W != BE_W * 8) $error("ppf_ctrl: DATA_W must be 8 bits per byte enable");
   end

   logic hit, mode_q, inv_now, par_raw;

   ppf_trigger #(.ARM_ON_WR(ARM_ON_WR), .ARM_ON_RDC(ARM_ON_RDC)) u_trig (
      .valid(up_valid), .perr(up_perr), .kind(up_kind), .en(poison_en), .hit(hit));

   ppf_poison_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .hit(hit), .clr(sts_clr),
      .mode_q(mode_q), .inv_now(inv_now));

   ppf_parity_gen #(.DATA_W(DATA_W), .BE_W(BE_W), .STYLE(PAR_STYLE)) u_par (
      .data(up_data), .be(up_be), .par(par_raw));

   ppf_out_stage #(.DATA_W(DATA_W), .BE_W(BE_W)) u_out (
      .clk(clk), .rst_n(rst_n), .in_valid(up_valid), .in_data(up_data),
      .in_be(up_be), .in_par(par_raw), .in_inv(inv_now),
      .out_valid(dn_valid), .out_data(dn_data), .out_be(dn_be), .out_par(dn_par));

   assign poison_sts = mode_q;

   p_good_par_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !inv_now) |=> (dn_par == ^{dn_data, dn_be}));
   p_bad_par_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && inv_now) |=> (dn_par != ^{dn_data, dn_be}));
   p_noarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!poison_en && !poison_sts) |=> !poison_sts);
   p_novalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_valid && !poison_sts) |=> !poison_sts);
endmodule

// File: tb/ppf_ctrl_bench.sv
`timescale 1ns/100ps
module ppf_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_valid = 0, up_perr = 0, up_kind = 0, poison_en = 0, sts_clr = 0;
   logic [31:0] up_data = '0;
   logic [3:0]  up_be = '0;
   logic        dn_valid, dn_par, poison_sts;
   logic [31:0] dn_data;
   logic [3:0]  dn_be;

   always #2.5 clk = ~clk;

   ppf_ctrl u_ppf_ctrl (
      .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_data(up_data), .up_be(up_be),
      .up_perr(up_perr), .up_kind(up_kind), .poison_en(poison_en), .sts_clr(sts_clr),
      .dn_valid(dn_valid), .dn_data(dn_data), .dn_be(dn_be), .dn_par(dn_par),
      .poison_sts(poison_sts));

   typedef struct {
      logic [31:0] data;
      logic [3:0]  be;
      logic        par;
      string       tag;
   } exp_t;

   exp_t  sb[$];
   int    n_checks = 0, n_fail = 0;
   logic  mdl_mode = 1'b0;
   string sts_tag = "R1";
   bit    mon_on = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // driver: one cycle of stimulus, model updated after the capturing edge
   task automatic cyc(input logic v, input logic [31:0] d, input logic [3:0] be,
                      input logic perr, input logic kind, input logic en,
                      input logic clr, input string tag);
      logic trig, inv;
      exp_t e;
      @(negedge clk);
      up_valid = v; up_data = d; up_be = be; up_perr = perr;
      up_kind = kind; poison_en = en; sts_clr = clr;
      trig = v & perr & en;
      inv  = trig | (mdl_mode & ~clr);
      if (v) begin
         e.data = d; e.be = be; e.par = (^{d, be}) ^ inv; e.tag = tag;
         sb.push_back(e);
      end
      @(posedge clk);
      #1;
      mdl_mode = inv;
      sts_tag  = tag;
   endtask

   // monitor: pops the scoreboard as beats leave the design
   always @(negedge clk) begin
      if (mon_on) begin
         check(poison_sts === mdl_mode, sts_tag, "poison_sts", 64'(poison_sts), 64'(mdl_mode));
         if (dn_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R2", "unexpected dn_valid", 64'(dn_valid), 64'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(dn_data === e.data && dn_be === e.be, e.tag, "data/be",
                     {28'd0, dn_be, dn_data}, {28'd0, e.be, e.data});
               check(dn_par === e.par, e.tag, "dn_par", 64'(dn_par), 64'(e.par));
            end
         end
      end
   end

   initial begin
      #200000;
      check(1'b0, "WATCHDOG", "timeout", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(dn_valid === 1'b0, "R1", "dn_valid in reset", 64'(dn_valid), 64'd0);
      check(poison_sts === 1'b0, "R1", "poison_sts in reset", 64'(poison_sts), 64'd0);
      @(negedge clk); rst_n = 1'b1;
      mon_on = 1'b1;
      // R2 / R3: plain forwarding, varied patterns
      cyc(1, 32'h0000_0000, 4'h0, 0, 0, 1, 0, "R3");
      cyc(1, 32'hFFFF_FFFF, 4'hF, 0, 0, 1, 0, "R3");
      cyc(1, 32'hA5A5_0001, 4'h3, 0, 1, 1, 0, "R2");
      cyc(0, 32'h1234_5678, 4'h1, 0, 0, 1, 0, "R2");
      cyc(1, 32'h8000_0000, 4'h8, 0, 0, 1, 0, "R3");
      // R8: disarmed error has no effect
      cyc(1, 32'hDEAD_BEEF, 4'hF, 1, 0, 0, 0, "R8");
      cyc(1, 32'h0F0F_0F0F, 4'h5, 0, 0, 0, 0, "R8");
      // R11: error flag with no valid beat
      cyc(0, 32'hCAFE_0000, 4'h2, 1, 0, 1, 0, "R11");
      cyc(1, 32'h0000_0007, 4'h1, 0, 0, 1, 0, "R11");
      // R4 / R5 / R6: write-data error arms the mode
      cyc(1, 32'h1111_2222, 4'hF, 1, 0, 1, 0, "R4");
      cyc(1, 32'h3333_4444, 4'hC, 0, 0, 1, 0, "R6");
      cyc(0, 32'h0, 4'h0, 0, 0, 1, 0, "R5");
      cyc(1, 32'h5555_6666, 4'h3, 0, 1, 1, 0, "R6");
      // R12: dropping the enable keeps the mode
      cyc(1, 32'h7777_8888, 4'hA, 0, 0, 0, 0, "R12");
      cyc(1, 32'h9999_AAAA, 4'h6, 1, 1, 0, 0, "R12");
      // R9: clear with a plain beat in the same cycle
      cyc(1, 32'hBBBB_CCCC, 4'hF, 0, 0, 1, 1, "R9");
      cyc(1, 32'hDDDD_EEEE, 4'h9, 0, 0, 1, 0, "R9");
      // R7: read-completion error also arms the mode
      cyc(1, 32'h0102_0304, 4'hF, 1, 1, 1, 0, "R7");
      cyc(1, 32'h0506_0708, 4'h4, 0, 0, 1, 0, "R7");
      // R10: error and clear in the same cycle, set wins
      cyc(1, 32'h1357_9BDF, 4'h7, 1, 0, 1, 1, "R10");
      cyc(1, 32'h2468_ACE0, 4'hE, 0, 0, 1, 0, "R10");
      // clear while idle, then normal traffic again
      cyc(0, 32'h0, 4'h0, 0, 0, 1, 1, "R9");
      cyc(1, 32'hFEDC_BA98, 4'hB, 0, 1, 1, 0, "R3");
      cyc(0, 32'h0, 4'h0, 0, 0, 1, 0, "R2");
      cyc(0, 32'h0, 4'h0, 0, 0, 1, 0, "R2");
      check(sb.size() == 0, "R2", "scoreboard drained", 64'(sb.size()), 64'd0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule